// File: doc/BRIEF.md
# Compressed Trie Step Engine

This block advances a multi-pattern string-matching automaton by one input byte. The automaton is stored as a trie in an on-chip node memory. Each node keeps a 256-bit child-presence bitmap, a base pointer to its packed children, a fallback (failure) pointer and a pointer into an action table. The engine takes a byte, a queue tag and the current node address. It reads the node and decides whether the byte has a child there. It then returns the address of the node to visit next. Children are not stored as a full 256-way array. A child's position is found by counting the set bitmap bits below the byte value, multiplying by the node size and adding the base pointer.

The first byte of each packet does not start at the root. Its start node comes from a 256-entry table indexed by the byte value. A flag marks when a step's effective address is the root node. A second flag marks when the node reached is a leaf. The leaf flag signals a signature match to downstream logic, which also receives the action pointer. Queue tags pass through the two-stage pipeline untouched. This lets the steps of several packets be interleaved cycle by cycle. Both the node memory and the entry table are filled through simple write ports before traffic starts.

Top module: `trie_step_unit`

## Requirements
- R1: A step presented with `in_valid` high appears on the outputs with `out_valid` high exactly two clock cycles later, carrying the same tag; no output is valid without a step two cycles earlier.
- R2: When `in_first` is high, the effective address is the 24-bit entry-table word at index `in_byte`; otherwise it is `in_addr`.
- R3: The bitmap bit at index `in_byte` of the node word (byte bits 7:5 pick one of eight 32-bit words, bits 4:0 the bit within it, bitmap occupying node bits 255:0) sets `out_hit`.
- R4: On a miss (`out_hit` low), `out_next` equals the node's failure pointer (node bits 303:280).
- R5: On a hit, `out_next` equals the node's child base pointer (node bits 279:256) plus 64 times the number of set bitmap bits at indices below `in_byte`.
- R6: The hit address sum saturates at 24'hFFFFFF instead of wrapping.
- R7: `out_root` is high exactly when the full 24-bit effective address is zero.
- R8: `out_match` is high exactly when the loaded child base pointer is zero (leaf node).
- R9: `out_rules` equals the node's action pointer (node bits 327:304).
- R10: The node read uses effective-address bits starting at bit 6; bits 5:0 select no different node.
- R11: While `rst_n` is low and right after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Step request |
| in_first | input | 1 | Byte is the first of its packet |
| in_byte | input | 8 | Input symbol |
| in_tag | input | TAG_W | Queue tag |
| in_addr | input | 24 | Current node byte address |
| mem_we | input | 1 | Node memory write enable |
| mem_waddr | input | LINE_AW | Node memory line to write |
| mem_wdata | input | 328 | Node word to write |
| tbl_we | input | 1 | Entry table write enable |
| tbl_waddr | input | 8 | Entry table index |
| tbl_wdata | input | 24 | Entry table start address |
| out_valid | output | 1 | Result valid |
| out_tag | output | TAG_W | Queue tag of the result |
| out_next | output | 24 | Next node address |
| out_hit | output | 1 | Child present for the byte |
| out_root | output | 1 | Effective address was the root |
| out_match | output | 1 | Node reached is a leaf |
| out_rules | output | 24 | Action pointer of the node |

## Verification
Two functions can land in the same cycle. In one, an entry-table lookup points at the root while the root's bitmap hit is counted. In the other, a full popcount drives the saturating add on a node whose base pointer sits near the top of the address range. Directed steps feed byte 0xFF and byte 0x00 into a root node whose bitmap is all ones and whose base is 24'hFFFF00. They also send a first byte whose table entry is zero. Each output field is then judged on its own against a behavioural model. Randomized steps with mixed first flags, tags and low address bits run next to them.

// File: rtl/trie_pkg.sv
package trie_pkg;
    localparam int PTR_W      = 24;
    localparam int BM_W       = 256;
    localparam int WORD_W     = 32;
    localparam int LINE_SHIFT = 6;
    localparam int NODE_W     = BM_W + 3 * PTR_W;

    typedef struct packed {
        logic [PTR_W-1:0] rules;
        logic [PTR_W-1:0] fail;
        logic [PTR_W-1:0] next;
        logic [BM_W-1:0]  bitmap;
    } node_t;
endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem
    import trie_pkg::*;
#(
    parameter int LINE_AW = 6
) (
    input  logic               clk,
    input  logic               we,
    input  logic [LINE_AW-1:0] waddr,
    input  node_t              wdata,
    input  logic [LINE_AW-1:0] raddr,
    output node_t              rdata
);
    localparam int DEPTH = 2 ** LINE_AW;

    node_t arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
        rdata <= arr[raddr];
    end
endmodule

// File: rtl/trie_entry_table.sv
module trie_entry_table
    import trie_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [SYM_W-1:0] waddr,
    input  logic [PTR_W-1:0] wdata,
    input  logic [SYM_W-1:0] raddr,
    output logic [PTR_W-1:0] rdata
);
    localparam int ENTRIES = 2 ** SYM_W;

    logic [PTR_W-1:0] tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wdata;
    end

    assign rdata = tbl[raddr];
endmodule

// File: rtl/trie_child_calc.sv
module trie_child_calc
    import trie_pkg::*;
(
    input  node_t            node,
    input  logic [7:0]       sym,
    output logic             hit,
    output logic [PTR_W-1:0] next_addr
);
    localparam int WORDS  = BM_W / WORD_W;
    localparam int SEL_W  = $clog2(WORDS);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int PART_W = BIT_W + 1;
    localparam int CNT_W  = $clog2(BM_W) + 1;

    function automatic logic [PART_W-1:0] popcnt(input logic [WORD_W-1:0] v);
        logic [PART_W-1:0] c;
        c = '0;
        for (int i = 0; i < WORD_W; i++) c += PART_W'(v[i]);
        return c;
    endfunction

    logic [SEL_W-1:0]  sel;
    logic [BIT_W-1:0]  bitpos;
    logic [PART_W-1:0] part [WORDS];
    logic [CNT_W-1:0]  total;
    logic [PTR_W:0]    wide;
    logic [PTR_W-1:0]  sat;

    assign sel    = sym[7 -: SEL_W];
    assign bitpos = sym[BIT_W-1:0];

    for (genvar g = 0; g < WORDS; g++) begin : g_unit
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] m;
        assign w = node.bitmap[g*WORD_W +: WORD_W];
        always_comb begin
            if (SEL_W'(g) < sel)       m = '1;
            else if (SEL_W'(g) == sel) m = (WORD_W'(1) << bitpos) - WORD_W'(1);
            else                       m = '0;
            part[g] = popcnt(w & m);
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < WORDS; i++) total += CNT_W'(part[i]);
        wide = {1'b0, node.next} + ((PTR_W + 1)'(total) << LINE_SHIFT);
        sat  = wide[PTR_W] ? '1 : wide[PTR_W-1:0];
        hit  = node.bitmap[sym];
        next_addr = hit ? sat : node.fail;
    end
endmodule

// File: rtl/trie_step_unit.sv
module trie_step_unit
    import trie_pkg::*;
#(
    parameter int LINE_AW = 6,
    parameter int TAG_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic [7:0]         in_byte,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic [23:0]        in_addr,
    input  logic               mem_we,
    input  logic [LINE_AW-1:0] mem_waddr,
    input  logic [327:0]       mem_wdata,
    input  logic               tbl_we,
    input  logic [7:0]         tbl_waddr,
    input  logic [23:0]        tbl_wdata,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag,
    output logic [23:0]        out_next,
    output logic               out_hit,
    output logic               out_root,
    output logic               out_match,
    output logic [23:0]        out_rules
);
    typedef struct packed {
        logic             s1_v;
        logic [7:0]       s1_sym;
        logic [TAG_W-1:0] s1_tag;
        logic             s1_root;
        logic             o_v;
        logic [TAG_W-1:0] o_tag;
        logic [PTR_W-1:0] o_next;
        logic             o_hit;
        logic             o_root;
        logic             o_match;
        logic [PTR_W-1:0] o_rules;
    } pipe_t;

    pipe_t            st_d, st_q;
    logic [PTR_W-1:0] tbl_rd;
    logic [PTR_W-1:0] eff_addr;
    node_t            node_rd;
    logic             calc_hit;
    logic [PTR_W-1:0] calc_next;

    trie_entry_table #(.SYM_W(8)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (in_byte),
        .rdata (tbl_rd)
    );

    assign eff_addr = in_first ? tbl_rd : in_addr;

    trie_node_mem #(.LINE_AW(LINE_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (node_t'(mem_wdata)),
        .raddr (eff_addr[LINE_SHIFT +: LINE_AW]),
        .rdata (node_rd)
    );

    trie_child_calc u_calc (
        .node      (node_rd),
        .sym       (st_q.s1_sym),
        .hit       (calc_hit),
        .next_addr (calc_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.s1_v    = in_valid;
        st_d.s1_sym  = in_byte;
        st_d.s1_tag  = in_tag;
        st_d.s1_root = (eff_addr == '0);
        st_d.o_v     = st_q.s1_v;
        st_d.o_tag   = st_q.s1_tag;
        st_d.o_next  = calc_next;
        st_d.o_hit   = calc_hit;
        st_d.o_root  = st_q.s1_root;
        st_d.o_match = (node_rd.next == '0);
        st_d.o_rules = node_rd.rules;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_v;
    assign out_tag   = st_q.o_tag;
    assign out_next  = st_q.o_next;
    assign out_hit   = st_q.o_hit;
    assign out_root  = st_q.o_root;
    assign out_match = st_q.o_match;
    assign out_rules = st_q.o_rules;

    // R1: a result only follows a request two cycles back
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R1: tag carried unchanged through both stages
    a_r1_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == $past(in_tag, 2));

    // R4: miss takes the fallback pointer of the node read
    a_r4_miss_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hit |-> out_next == $past(node_rd.fail));

    // R6: hit address never drops below the child base
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hit |-> out_next >= $past(node_rd.next));

    // R8: leaf flag only from a null child base
    a_r8_leaf_null: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_match |-> $past(node_rd.next) == '0);
endmodule

// File: tb/tb_trie_step_unit.sv
`timescale 1ns/1ps
module tb_trie_step_unit;
    localparam int LINE_AW = 6;
    localparam int TAG_W   = 3;
    localparam int LINES   = 2 ** LINE_AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               in_valid, in_first;
    logic [7:0]         in_byte;
    logic [TAG_W-1:0]   in_tag;
    logic [23:0]        in_addr;
    logic               mem_we;
    logic [LINE_AW-1:0] mem_waddr;
    logic [327:0]       mem_wdata;
    logic               tbl_we;
    logic [7:0]         tbl_waddr;
    logic [23:0]        tbl_wdata;
    logic               out_valid;
    logic [TAG_W-1:0]   out_tag;
    logic [23:0]        out_next;
    logic               out_hit, out_root, out_match;
    logic [23:0]        out_rules;

    trie_step_unit #(.LINE_AW(LINE_AW), .TAG_W(TAG_W)) dut (.*);

    logic [255:0] m_bm [LINES];
    logic [23:0]  m_nx [LINES];
    logic [23:0]  m_fl [LINES];
    logic [23:0]  m_rl [LINES];
    logic [23:0]  m_tb [256];

    typedef struct {
        bit         v;
        logic [TAG_W-1:0] tag;
        logic [23:0] nx;
        bit         hit, root, match;
        logic [23:0] rl;
        string      nreq;
    } exp_t;

    exp_t p0, p1;
    int   vecs = 0, miss = 0;
    bit   done = 1'b0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(bit v, bit first, logic [7:0] b,
                                   logic [TAG_W-1:0] tg, logic [23:0] a);
        exp_t e;
        logic [23:0] eff;
        int line, cnt;
        longint sum;
        eff  = first ? m_tb[b] : a;        // R2
        line = int'(eff[6 +: LINE_AW]);    // R10
        cnt  = 0;
        for (int i = 0; i < int'(b); i++) cnt += int'(m_bm[line][i]);
        e.v     = v;
        e.tag   = tg;
        e.hit   = m_bm[line][b];           // R3
        sum     = longint'(m_nx[line]) + longint'(cnt) * 64;
        e.nreq  = "R4";
        if (e.hit) begin
            e.nreq = "R5";
            if (sum > 64'hFFFFFF) begin sum = 64'hFFFFFF; e.nreq = "R6"; end
            e.nx = sum[23:0];
        end else begin
            e.nx = m_fl[line];
        end
        if (first) e.nreq = "R2";
        else if (a[5:0] != 6'd0) e.nreq = "R10";
        e.root  = (eff == 24'd0);          // R7
        e.match = (m_nx[line] == 24'd0);   // R8
        e.rl    = m_rl[line];              // R9
        return e;
    endfunction

    task automatic step(bit v, bit first, logic [7:0] b, logic [TAG_W-1:0] tg, logic [23:0] a);
        @(negedge clk);
        chk("R1", "valid", 32'(out_valid), 32'(p1.v));
        if (p1.v && out_valid) begin
            chk("R1", "tag", 32'(out_tag), 32'(p1.tag));
            chk(p1.nreq, "next", 32'(out_next), 32'(p1.nx));
            chk("R3", "hit", 32'(out_hit), 32'(p1.hit));
            chk("R7", "root", 32'(out_root), 32'(p1.root));
            chk("R8", "match", 32'(out_match), 32'(p1.match));
            chk("R9", "rules", 32'(out_rules), 32'(p1.rl));
        end
        p1 = p0;
        p0 = model(v, first, b, tg, a);
        in_valid = v; in_first = first; in_byte = b; in_tag = tg; in_addr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; in_first = 0; in_byte = 0; in_tag = 0; in_addr = 0;
        mem_we = 0; mem_waddr = 0; mem_wdata = 0; tbl_we = 0; tbl_waddr = 0; tbl_wdata = 0;
        p0 = '{default: 0, nreq: ""};
        p1 = '{default: 0, nreq: ""};
        repeat (3) @(negedge clk);
        chk("R11", "valid in reset", 32'(out_valid), 0);
        rst_n = 1'b1;

        for (int l = 0; l < LINES; l++) begin
            if (l == 0)      m_bm[l] = '1;
            else if (l == 1) m_bm[l] = '0;
            else if (l == 2) m_bm[l] = 256'd1 << 255;
            else m_bm[l] = {$urandom, $urandom, $urandom, $urandom,
                            $urandom, $urandom, $urandom, $urandom};
            m_nx[l] = 24'($urandom) & 24'h0FFFC0;
            if (l == 0 || l == 5) m_nx[l] = 24'hFFFF00;
            if (l == 3 || l % 7 == 6) m_nx[l] = 24'd0;
            m_fl[l] = 24'($urandom);
            m_rl[l] = 24'($urandom);
            @(negedge clk);
            mem_we = 1; mem_waddr = LINE_AW'(l);
            mem_wdata = {m_rl[l], m_fl[l], m_nx[l], m_bm[l]};
        end
        @(negedge clk);
        mem_we = 0;
        for (int b = 0; b < 256; b++) begin
            m_tb[b] = 24'(((b * 7) % LINES) << 6);
            if (b == 8'h41) m_tb[b] = 24'd0;
            @(negedge clk);
            tbl_we = 1; tbl_waddr = 8'(b); tbl_wdata = m_tb[b];
        end
        @(negedge clk);
        tbl_we = 0;
        chk("R11", "valid after reset", 32'(out_valid), 0);

        // R6 with R7: full popcount on root with high base
        step(1, 0, 8'hFF, 3'd1, 24'h000000);
        step(1, 0, 8'h00, 3'd2, 24'h000000);
        // R4: empty bitmap always misses
        step(1, 0, 8'h55, 3'd3, 24'h000040);
        // R3: single high bit, hit and neighbour miss
        step(1, 0, 8'hFF, 3'd4, 24'h000080);
        step(1, 0, 8'hFE, 3'd5, 24'h000080);
        // R8: leaf node
        step(1, 0, 8'h1F, 3'd6, 24'h0000C0);
        // R2 with R7: first byte whose entry is the root
        step(1, 1, 8'h41, 3'd7, 24'h000140);
        step(1, 1, 8'h20, 3'd0, 24'h000000);
        // R10: low address bits select the same node
        step(1, 0, 8'h20, 3'd1, 24'h0000C5);
        step(1, 0, 8'h20, 3'd1, 24'h0000FF);
        // R1: bubbles between steps
        step(0, 0, 8'h00, 3'd0, 24'h0);
        step(1, 0, 8'h80, 3'd2, 24'h000100);
        step(0, 0, 8'h00, 3'd0, 24'h0);

        for (int k = 0; k < 4000; k++) begin
            logic [23:0] a;
            a = 24'($urandom);
            if ($urandom % 4 == 0) a[5:0] = 6'd0;
            if ($urandom % 16 == 0) a = 24'd0;
            step(($urandom % 5) != 0, ($urandom % 4) == 0, 8'($urandom),
                 TAG_W'($urandom), a);
        end
        step(0, 0, 8'h0, 3'd0, 24'h0);
        step(0, 0, 8'h0, 3'd0, 24'h0);
        step(0, 0, 8'h0, 3'd0, 24'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule